// File: doc/BRIEF.md
# Inter-Processor Interrupt Command Unit

This block is the send side of an inter-processor interrupt path. A processor programs it over a simple 32-bit register bus. The block sits on one 12-bit offset window and has three registers: a destination word, a command word and an error word.

Software first writes the target identifier into the destination word. It then writes the command word, and that write launches a message at once. The block decodes the destination shorthand into explicit target-selection flags. It applies the per-kind rules on trigger and level, and presents the message on an outbound valid/ready port. A busy bit in the command word reads 1 from the launch until the outbound side accepts the message, so software polls that bit before it writes the next command.

The outbound port follows the usual back-pressure rules:
- `out_valid` rises in the cycle after a launching write.
- While `out_ready` is low, the valid flag and every message field hold unchanged.
- The transfer completes in the first cycle in which both `out_valid` and `out_ready` are high. `out_valid` is low in the following cycle.
- No new message can start while one is outstanding.
- The receiving side may flag a checksum or accept problem. It does so on `out_cs_err` and `out_acc_err` in the transfer cycle.

Top module: `ipi_cmd_unit`

## Requirements
- R1: After reset, `out_valid` is low and reads of the command word, the destination word and the error word return 0.
- R2: The destination word sits at offset 0x310. A write there keeps bits 31:24 as the target identifier, and a read returns that identifier in bits 31:24 with all other bits 0.
- R3: The command word sits at offset 0x300. A write there while idle raises `out_valid` in the next cycle. The word stores the vector in bits 7:0, the kind in bits 10:8 (000 fixed, 001 lowest priority, 010 SMI, 100 NMI, 101 INIT, 110 startup), the level flag in bit 14 (1 assert), the trigger in bit 15 (1 level, 0 edge) and the shorthand in bits 19:18. A read returns these fields, with bit 12 = busy and bits 17:16 (remote-read status) always 00.
- R4: The shorthand selects the targets:
  - 00 gives `out_dest` = the stored identifier and `out_id_match`=1.
  - 01 gives `out_dest` = `self_id` and `out_to_self`=1.
  - 10 gives `out_to_self` = `out_to_others` = 1.
  - 11 gives only `out_to_others`=1.
  - For 10 and 11, `out_dest` is 0xFF.
  - `out_id_match` is 0 for every shorthand except 00.
- R5: While `out_valid` is high and `out_ready` is low, the message is held stable. After the transfer cycle, `out_valid` and busy (bit 12) are low.
- R6: A command-word write while busy is ignored. The outstanding message and the stored fields do not change.
- R7: A startup message (kind 110) is always sent edge-triggered (`out_trig_lvl`=0) with `out_level`=1, whatever the written flags say.
- R8: An INIT message with level flag 0 and shorthand 10 sets `out_sync_bcast`=1, meaning a broadcast with no identifier check. Every other message has `out_sync_bcast`=0.
- R9: A fixed or lowest-priority command with a vector below 16 is not launched, and it sets error bit 5.
- R10: A transfer with `out_cs_err` high sets error bit 0. A transfer with `out_acc_err` high sets error bit 2.
- R11: Any access to an offset other than 0x280, 0x300 or 0x310 sets error bit 7. Such a read returns 0.
- R12: The error word sits at offset 0x280. A read returns the latched copy only. A write of any value moves the accumulated flags into that copy and clears the accumulator, so a new error becomes visible only after the next write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| self_id | input | 8 | Identifier of the local processor |
| out_valid | output | 1 | Message is presented |
| out_ready | input | 1 | Receiver accepts the message |
| out_vector | output | 8 | Vector or startup page |
| out_kind | output | 3 | Message kind |
| out_level | output | 1 | Assert (1) or de-assert (0) |
| out_trig_lvl | output | 1 | Level (1) or edge (0) trigger |
| out_dest | output | 8 | Destination identifier |
| out_id_match | output | 1 | Receivers compare against `out_dest` |
| out_to_self | output | 1 | Sender is a target |
| out_to_others | output | 1 | All other processors are targets |
| out_sync_bcast | output | 1 | Broadcast with no identifier check |
| out_cs_err | input | 1 | Checksum problem reported with the transfer |
| out_acc_err | input | 1 | Accept problem reported with the transfer |

## Verification
The assertions assume a well-behaved bus. There is at most one access per cycle, `bus_addr`, `bus_we` and `bus_wdata` are defined whenever `bus_sel` is high, and `out_ready` and the two error inputs are defined at every clock edge after reset.

The bench drives all of these on the falling edge from single-access tasks. It keeps the error inputs low except in the transfer cycle of the handshake-error scenario. It raises `out_ready` only inside an accept task, so every back-pressure window has a known length.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

  localparam int ID_W  = 8;
  localparam int VEC_W = 8;
  localparam int ERR_W = 8;
  localparam int NUM_REGS = 3;

  // register map, index order used by the decoder hit vector
  localparam int IDX_ERR = 0;
  localparam int IDX_LO  = 1;
  localparam int IDX_HI  = 2;
  localparam logic [11:0] REG_MAP [NUM_REGS] = '{12'h280, 12'h300, 12'h310};

  // command word field positions
  localparam int KIND_LSB  = 8;
  localparam int BUSY_BIT  = 12;
  localparam int LEVEL_BIT = 14;
  localparam int TRIG_BIT  = 15;
  localparam int SH_LSB    = 18;

  // error word flag positions
  localparam int ERR_CS  = 0;
  localparam int ERR_ACC = 2;
  localparam int ERR_VEC = 5;
  localparam int ERR_REG = 7;

  typedef enum logic [2:0] {
    KIND_FIXED  = 3'b000,
    KIND_LOWEST = 3'b001,
    KIND_SMI    = 3'b010,
    KIND_NMI    = 3'b100,
    KIND_INIT   = 3'b101,
    KIND_START  = 3'b110
  } kind_e;

  typedef enum logic [1:0] {
    SH_NONE   = 2'b00,
    SH_SELF   = 2'b01,
    SH_ALL    = 2'b10,
    SH_OTHERS = 2'b11
  } short_e;

  typedef struct packed {
    logic [1:0]       shorthand;
    logic             trig_lvl;
    logic             level;
    logic [2:0]       kind;
    logic [VEC_W-1:0] vector;
  } cmd_t;

  typedef struct packed {
    logic [ID_W-1:0]  dest;
    logic             id_match;
    logic             to_self;
    logic             to_others;
    logic             sync_bcast;
    logic             level;
    logic             trig_lvl;
    logic [2:0]       kind;
    logic [VEC_W-1:0] vector;
  } msg_t;

endpackage

// File: rtl/ipi_reg_decode.sv
module ipi_reg_decode
  import ipi_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic                bus_sel,
  input  logic [ADDR_W-1:0]   bus_addr,
  output logic [NUM_REGS-1:0] hit,
  output logic                bad_addr
);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_hit
    assign hit[i] = bus_sel && (bus_addr == ADDR_W'(REG_MAP[i]));
  end

  assign bad_addr = bus_sel && !(|hit);

endmodule

// File: rtl/ipi_msg_former.sv
module ipi_msg_former
  import ipi_pkg::*;
#(
  parameter int MIN_VEC = 16
) (
  input  cmd_t            cmd,
  input  logic [ID_W-1:0] dest_id,
  input  logic [ID_W-1:0] self_id,
  output msg_t            msg,
  output logic            vec_ok
);

  logic needs_vec;

  always_comb begin
    msg            = '0;
    msg.vector     = cmd.vector;
    msg.kind       = cmd.kind;
    msg.level      = cmd.level;
    msg.trig_lvl   = cmd.trig_lvl;

    // startup is always an asserted edge
    if (cmd.kind == KIND_START) begin
      msg.trig_lvl = 1'b0;
      msg.level    = 1'b1;
    end

    case (cmd.shorthand)
      SH_NONE: begin
        msg.dest     = dest_id;
        msg.id_match = 1'b1;
      end
      SH_SELF: begin
        msg.dest    = self_id;
        msg.to_self = 1'b1;
      end
      SH_ALL: begin
        msg.dest      = '1;
        msg.to_self   = 1'b1;
        msg.to_others = 1'b1;
      end
      default: begin
        msg.dest      = '1;
        msg.to_others = 1'b1;
      end
    endcase

    msg.sync_bcast = (cmd.kind == KIND_INIT) && !cmd.level &&
                     (cmd.shorthand == SH_ALL);
  end

  assign needs_vec = (cmd.kind == KIND_FIXED) || (cmd.kind == KIND_LOWEST);
  assign vec_ok    = !(needs_vec && (cmd.vector < VEC_W'(MIN_VEC)));

endmodule

// File: rtl/ipi_send_ctrl.sv
module ipi_send_ctrl
  import ipi_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  input  msg_t msg_in,
  input  logic out_ready,
  output logic out_valid,
  output msg_t msg_q,
  output logic accept
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      msg_q     <= '0;
    end else if (!out_valid) begin
      if (launch) begin
        out_valid <= 1'b1;
        msg_q     <= msg_in;
      end
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assign accept = out_valid && out_ready;

endmodule

// File: rtl/ipi_err_status.sv
module ipi_err_status
  import ipi_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ERR_W-1:0] set_bits,
  input  logic             flush,
  output logic [ERR_W-1:0] copy_q
);

  logic [ERR_W-1:0] acc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q  <= '0;
      copy_q <= '0;
    end else if (flush) begin
      copy_q <= acc_q;
      acc_q  <= set_bits;
    end else begin
      acc_q <= acc_q | set_bits;
    end
  end

endmodule

// File: rtl/ipi_cmd_unit.sv
module ipi_cmd_unit
  import ipi_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32,
  parameter int MIN_VEC = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [ID_W-1:0]   self_id,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [VEC_W-1:0]  out_vector,
  output logic [2:0]        out_kind,
  output logic              out_level,
  output logic              out_trig_lvl,
  output logic [ID_W-1:0]   out_dest,
  output logic              out_id_match,
  output logic              out_to_self,
  output logic              out_to_others,
  output logic              out_sync_bcast,
  input  logic              out_cs_err,
  input  logic              out_acc_err
);

  localparam int ID_LSB = DATA_W - ID_W;

  logic [NUM_REGS-1:0] hit;
  logic                bad_addr;
  logic [ID_W-1:0]     hi_id_q;
  cmd_t                cmd_q, cmd_next;
  msg_t                msg_new, msg_q;
  logic                vec_ok, cmd_wr, launch, accept;
  logic [ERR_W-1:0]    err_set, err_copy;
  logic                wdata_unused;

  ipi_reg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .bus_sel  (bus_sel),
    .bus_addr (bus_addr),
    .hit      (hit),
    .bad_addr (bad_addr)
  );

  // field extraction of a command write
  always_comb begin
    cmd_next           = '0;
    cmd_next.vector    = bus_wdata[VEC_W-1:0];
    cmd_next.kind      = bus_wdata[KIND_LSB +: 3];
    cmd_next.level     = bus_wdata[LEVEL_BIT];
    cmd_next.trig_lvl  = bus_wdata[TRIG_BIT];
    cmd_next.shorthand = bus_wdata[SH_LSB +: 2];
  end
  assign wdata_unused = ^bus_wdata;

  assign cmd_wr = hit[IDX_LO] && bus_we && !out_valid;
  assign launch = cmd_wr && vec_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_id_q <= '0;
      cmd_q   <= '0;
    end else begin
      if (hit[IDX_HI] && bus_we) hi_id_q <= bus_wdata[DATA_W-1:ID_LSB];
      if (cmd_wr)                cmd_q   <= cmd_next;
    end
  end

  ipi_msg_former #(.MIN_VEC(MIN_VEC)) u_form (
    .cmd     (cmd_next),
    .dest_id (hi_id_q),
    .self_id (self_id),
    .msg     (msg_new),
    .vec_ok  (vec_ok)
  );

  ipi_send_ctrl u_send (
    .clk       (clk),
    .rst_n     (rst_n),
    .launch    (launch),
    .msg_in    (msg_new),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .msg_q     (msg_q),
    .accept    (accept)
  );

  always_comb begin
    err_set          = '0;
    err_set[ERR_CS]  = accept && out_cs_err;
    err_set[ERR_ACC] = accept && out_acc_err;
    err_set[ERR_VEC] = cmd_wr && !vec_ok;
    err_set[ERR_REG] = bad_addr;
  end

  ipi_err_status u_err (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_bits (err_set),
    .flush    (hit[IDX_ERR] && bus_we),
    .copy_q   (err_copy)
  );

  assign out_vector     = msg_q.vector;
  assign out_kind       = msg_q.kind;
  assign out_level      = msg_q.level;
  assign out_trig_lvl   = msg_q.trig_lvl;
  assign out_dest       = msg_q.dest;
  assign out_id_match   = msg_q.id_match;
  assign out_to_self    = msg_q.to_self;
  assign out_to_others  = msg_q.to_others;
  assign out_sync_bcast = msg_q.sync_bcast;

  // read mux; remote-read status bits stay 00
  always_comb begin
    bus_rdata = '0;
    if (hit[IDX_LO]) begin
      bus_rdata[VEC_W-1:0]      = cmd_q.vector;
      bus_rdata[KIND_LSB +: 3]  = cmd_q.kind;
      bus_rdata[BUSY_BIT]       = out_valid;
      bus_rdata[LEVEL_BIT]      = cmd_q.level;
      bus_rdata[TRIG_BIT]       = cmd_q.trig_lvl;
      bus_rdata[SH_LSB +: 2]    = cmd_q.shorthand;
    end else if (hit[IDX_HI]) begin
      bus_rdata[DATA_W-1:ID_LSB] = hi_id_q;
    end else if (hit[IDX_ERR]) begin
      bus_rdata[ERR_W-1:0] = err_copy;
    end
  end

endmodule

// File: rtl/ipi_cmd_unit_chk.sv
module ipi_cmd_unit_chk
  import ipi_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32,
  parameter int MIN_VEC = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              out_valid,
  input logic              out_ready,
  input logic [VEC_W-1:0]  out_vector,
  input logic [2:0]        out_kind,
  input logic              out_level,
  input logic              out_trig_lvl,
  input logic [ID_W-1:0]   out_dest,
  input logic              out_id_match,
  input logic              out_to_self,
  input logic              out_to_others
);

  logic mapped, lo_write, short_vec;
  assign mapped = (bus_addr == ADDR_W'(REG_MAP[0])) ||
                  (bus_addr == ADDR_W'(REG_MAP[1])) ||
                  (bus_addr == ADDR_W'(REG_MAP[2]));
  assign lo_write  = bus_sel && bus_we && (bus_addr == ADDR_W'(REG_MAP[IDX_LO]));
  assign short_vec = (bus_wdata[KIND_LSB +: 3] == KIND_FIXED ||
                      bus_wdata[KIND_LSB +: 3] == KIND_LOWEST) &&
                     (bus_wdata[VEC_W-1:0] < VEC_W'(MIN_VEC));

  a_r5_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_vector) &&
    $stable(out_dest) && $stable(out_kind) && $stable(out_level));

  a_r5_drop_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |=> !out_valid);

  a_r4_target_select: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_id_match ? !(out_to_self || out_to_others)
                                : (out_to_self || out_to_others)));

  a_r7_startup_edge: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_kind == KIND_START |-> !out_trig_lvl && out_level);

  a_r9_short_vector_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    lo_write && !out_valid && short_vec |=> !out_valid);

  a_r11_unmapped_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel && !bus_we && !mapped |-> bus_rdata == '0);

endmodule

bind ipi_cmd_unit ipi_cmd_unit_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MIN_VEC(MIN_VEC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .out_valid(out_valid), .out_ready(out_ready), .out_vector(out_vector),
  .out_kind(out_kind), .out_level(out_level), .out_trig_lvl(out_trig_lvl),
  .out_dest(out_dest), .out_id_match(out_id_match),
  .out_to_self(out_to_self), .out_to_others(out_to_others)
);

// File: tb/ipi_cmd_unit_tb.sv
`timescale 1ns/1ps
module ipi_cmd_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  self_id = 8'h07;
  logic        out_valid, out_ready = 1'b0;
  logic [7:0]  out_vector, out_dest;
  logic [2:0]  out_kind;
  logic        out_level, out_trig_lvl, out_id_match, out_to_self;
  logic        out_to_others, out_sync_bcast;
  logic        out_cs_err = 1'b0, out_acc_err = 1'b0;

  int n_checks = 0;
  int n_fails  = 0;

  localparam logic [11:0] A_ERR = 12'h280, A_LO = 12'h300, A_HI = 12'h310;

  always #2.5 clk = ~clk;

  ipi_cmd_unit dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .self_id(self_id), .out_valid(out_valid), .out_ready(out_ready),
    .out_vector(out_vector), .out_kind(out_kind), .out_level(out_level),
    .out_trig_lvl(out_trig_lvl), .out_dest(out_dest),
    .out_id_match(out_id_match), .out_to_self(out_to_self),
    .out_to_others(out_to_others), .out_sync_bcast(out_sync_bcast),
    .out_cs_err(out_cs_err), .out_acc_err(out_acc_err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic accept(input logic cs, input logic ae);
    @(negedge clk);
    out_ready = 1'b1; out_cs_err = cs; out_acc_err = ae;
    @(negedge clk);
    out_ready = 1'b0; out_cs_err = 1'b0; out_acc_err = 1'b0;
  endtask

  task automatic err_flush();
    bus_write(A_ERR, 32'h0);
    bus_write(A_ERR, 32'h0);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 out_valid", {31'b0, out_valid}, 32'h0);
    bus_read(A_LO, d);  check("R1 cmd word", d, 32'h0);
    bus_read(A_HI, d);  check("R1 dest word", d, 32'h0);
    bus_read(A_ERR, d); check("R1 err word", d, 32'h0);
  endtask

  task automatic t_dest_word();
    logic [31:0] d;
    bus_write(A_HI, 32'hA5FF_FFFF);
    bus_read(A_HI, d); check("R2 dest readback", d, 32'hA500_0000);
  endtask

  task automatic t_explicit();
    logic [31:0] d;
    bus_write(A_LO, 32'h0003_C031);
    check("R3 valid", {31'b0, out_valid}, 32'h1);
    check("R3 vector", {24'b0, out_vector}, 32'h31);
    check("R4 explicit dest", {24'b0, out_dest}, 32'hA5);
    check("R4 explicit flags", {28'b0, out_id_match, out_to_self, out_to_others, out_sync_bcast}, 32'h8);
    bus_read(A_LO, d); check("R3 cmd readback busy", d, 32'h0000_D031);
    accept(1'b0, 1'b0);
  endtask

  task automatic t_self();
    bus_write(A_LO, 32'h0004_0402);
    check("R4 self dest", {24'b0, out_dest}, 32'h07);
    check("R4 self flags", {28'b0, out_id_match, out_to_self, out_to_others, out_sync_bcast}, 32'h4);
    check("R3 kind nmi", {29'b0, out_kind}, 32'h4);
    accept(1'b0, 1'b0);
  endtask

  task automatic t_all_init();
    bus_write(A_LO, 32'h0008_8500);
    check("R4 all dest", {24'b0, out_dest}, 32'hFF);
    check("R8 all flags sync", {28'b0, out_id_match, out_to_self, out_to_others, out_sync_bcast}, 32'h7);
    accept(1'b0, 1'b0);
  endtask

  task automatic t_others();
    bus_write(A_LO, 32'h000C_0020);
    check("R4 others flags", {28'b0, out_id_match, out_to_self, out_to_others, out_sync_bcast}, 32'h2);
    accept(1'b0, 1'b0);
  endtask

  task automatic t_backpressure();
    logic [31:0] d;
    bus_write(A_LO, 32'h0000_0050);
    repeat (3) @(negedge clk);
    check("R5 held valid", {31'b0, out_valid}, 32'h1);
    check("R5 held vector", {24'b0, out_vector}, 32'h50);
    bus_write(A_LO, 32'h0000_0060);
    check("R6 busy write ignored out", {24'b0, out_vector}, 32'h50);
    bus_read(A_LO, d); check("R6 busy write ignored reg", d, 32'h0000_1050);
    accept(1'b0, 1'b0);
    check("R5 valid after accept", {31'b0, out_valid}, 32'h0);
    bus_read(A_LO, d); check("R5 busy cleared", d, 32'h0000_0050);
  endtask

  task automatic t_startup();
    bus_write(A_LO, 32'h0000_8609);
    check("R7 startup level/trig", {30'b0, out_level, out_trig_lvl}, 32'h2);
    check("R8 startup no sync", {31'b0, out_sync_bcast}, 32'h0);
    accept(1'b0, 1'b0);
  endtask

  task automatic t_illegal_vec();
    logic [31:0] d;
    err_flush();
    bus_write(A_LO, 32'h0000_0005);
    check("R9 not launched", {31'b0, out_valid}, 32'h0);
    bus_write(A_ERR, 32'h0);
    bus_read(A_ERR, d); check("R9 vector flag", d, 32'h20);
  endtask

  task automatic t_hs_err();
    logic [31:0] d;
    err_flush();
    bus_write(A_LO, 32'h0000_0040);
    accept(1'b1, 1'b1);
    bus_write(A_ERR, 32'h0);
    bus_read(A_ERR, d); check("R10 cs/accept flags", d, 32'h05);
  endtask

  task automatic t_bad_addr();
    logic [31:0] d;
    err_flush();
    bus_read(12'h123, d); check("R11 unmapped read zero", d, 32'h0);
    bus_read(A_ERR, d);   check("R12 copy not yet updated", d, 32'h0);
    bus_write(A_ERR, 32'hFFFF_FFFF);
    bus_read(A_ERR, d);   check("R11 register flag", d, 32'h80);
    bus_write(A_ERR, 32'h0);
    bus_read(A_ERR, d);   check("R12 accumulator cleared", d, 32'h0);
  endtask

  initial begin
    fork
      begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_dest_word();
        t_explicit();
        t_self();
        t_all_init();
        t_others();
        t_backpressure();
        t_startup();
        t_illegal_vec();
        t_hs_err();
        t_bad_addr();
      end
      begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule